// File: doc/BRIEF.md
# Quadrature-Capable Reload/Capture Timer

This block is a 16-bit core timer with two 16-bit auxiliary registers beside it. The core timer can step on a prescaled system clock, on a prescaled clock that is qualified by an external gate level, on chosen edges of an external count pin, or under a two-phase position sensor. In the last case the timer value follows the sensor position. In the first three modes the software direction bit sets the count direction, and an external direction pin can invert it when that pin is enabled. Each wrap of the core timer in either direction flips a toggle latch and raises a one-cycle interrupt. The latch state drives the toggle output.

Each auxiliary register can hold a value, capture the core value on a rising edge of its own pin, reload the core on a rising edge of its own pin, or reload the core when the toggle latch makes a chosen transition. If one register is set to reload on the latch rising and the other to reload on the latch falling, the block produces a continuous PWM wave on the toggle output. The high and low times of that wave come from the two register values, and no software is needed to keep it running. Simple write ports load the core and each auxiliary register directly.

Top module: `qrt_timer`

## Requirements
- R1: After reset, the core value, both auxiliary values, the toggle output and all three interrupt outputs are zero.
- R2: When core_mode is 00 (timer), the core steps once every 2^(prescale_sel+3) clocks. The prescaler starts at zero on reset and runs freely.
- R3: When core_mode is 01 (gated), the core steps at the same prescaler ticks, but only while the synchronised cnt_in equals gate_level.
- R4: When core_mode is 10 (counter), the core steps on cnt_in edges chosen by edge_sel: bit 0 selects rising edges and bit 1 selects falling edges. External pins pass through two synchronising flops, so a pin change acts at the third rising clock edge after it.
- R5: In the timer, gated and counter modes, count_down=1 makes the core count down. When ext_dir_en=1, a high level on dir_in inverts the selected direction.
- R6: When core_mode is 11 (sensor), cnt_in is phase A and dir_in is phase B. A change on exactly one phase steps the core up when the new A XOR the previous B is 1, and down otherwise. A change on both phases in the same cycle does nothing.
- R7: Stepping up from 0xFFFF gives 0x0000, and stepping down from 0x0000 gives 0xFFFF. Each such wrap flips toggle_out, and core_irq is high for one cycle, in the same cycle as the flip.
- R8: With aux mode 01 (capture), a rising edge on the register's pin copies the core value of that cycle into the register and pulses its interrupt for one cycle.
- R9: With aux mode 10 (pin reload), a rising edge on the register's pin loads the core from that register and pulses its interrupt.
- R10: With aux mode 11 (latch reload), a wrap whose latch transition matches the register's fall select loads the core from the register instead of the wrapped value. A fall select of 0 matches the latch going 0 to 1, and 1 matches 1 to 0. If both registers request a reload in the same cycle, register A wins.
- R11: An auxiliary register never counts. It changes only on its own write or a capture, and its write beats a capture. A core write beats every reload and step, and a core write cancels any wrap in that cycle.
- R12: When A reloads on the latch rising and B reloads on the latch falling, toggle_out runs as a continuous PWM. In up-counting timer mode, the high time is (0x10000 - A) ticks and the low time is (0x10000 - B) ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_mode | input | 2 | 00 timer, 01 gated, 10 counter, 11 sensor |
| prescale_sel | input | 3 | Prescaler exponent minus three |
| count_down | input | 1 | Software direction, 1 = down |
| ext_dir_en | input | 1 | Let dir_in invert the direction |
| edge_sel | input | 2 | Counter edges: bit0 rising, bit1 falling |
| gate_level | input | 1 | Gate level that allows counting |
| cnt_in | input | 1 | Count, gate or phase A pin |
| dir_in | input | 1 | Direction or phase B pin |
| aux_a_in | input | 1 | Trigger pin of register A |
| aux_b_in | input | 1 | Trigger pin of register B |
| aux_a_mode | input | 2 | 00 hold, 01 capture, 10 pin reload, 11 latch reload |
| aux_a_fall | input | 1 | Latch reload on falling latch (A) |
| aux_b_mode | input | 2 | Mode of register B, same coding |
| aux_b_fall | input | 1 | Latch reload on falling latch (B) |
| core_wr | input | 1 | Write strobe for the core |
| core_wdata | input | 16 | Core write data |
| aux_a_wr | input | 1 | Write strobe for register A |
| aux_a_wdata | input | 16 | Register A write data |
| aux_b_wr | input | 1 | Write strobe for register B |
| aux_b_wdata | input | 16 | Register B write data |
| core_value | output | 16 | Core timer value |
| toggle_out | output | 1 | Toggle latch |
| core_irq | output | 1 | Wrap interrupt pulse |
| aux_a_value | output | 16 | Register A value |
| aux_a_irq | output | 1 | Capture/reload pulse of A |
| aux_b_value | output | 16 | Register B value |
| aux_b_irq | output | 1 | Capture/reload pulse of B |

## Verification
A wrong prescaler phase, synchroniser depth or quadrature decode shows up as core_value differing from the model on the very clock where a step is, or is not, taken. For prescaled modes that clock is at most 1024 clocks away. A wrong latch or wrap rule first shows on toggle_out and core_irq in the wrap cycle. From then on it keeps showing as a shifted PWM high or low time, because the next reload starts from a different point. A wrong capture or reload priority shows on the auxiliary values, and on the core, one clock after the pin edge is seen.

// File: rtl/qrt_pkg.sv
package qrt_pkg;
  typedef enum logic [1:0] {
    CM_TIMER = 2'b00,
    CM_GATED = 2'b01,
    CM_COUNT = 2'b10,
    CM_QUAD  = 2'b11
  } core_mode_t;

  typedef enum logic [1:0] {
    AM_HOLD       = 2'b00,
    AM_CAPTURE    = 2'b01,
    AM_PIN_LOAD   = 2'b10,
    AM_LATCH_LOAD = 2'b11
  } aux_mode_t;

  // direction of one quadrature step: new phase A against old phase B
  function automatic logic quad_up(input logic a_new, input logic b_old);
    return a_new ^ b_old;
  endfunction
endpackage

// File: rtl/qrt_insync.sv
module qrt_insync #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] lvl,
  output logic [N-1:0] prv
);
  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_lane
      logic s1, s2, pv;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          s1 <= 1'b0;
          s2 <= 1'b0;
          pv <= 1'b0;
        end else begin
          s1 <= raw[i];
          s2 <= s1;
          pv <= s2;
        end
      end
      assign lvl[i] = s2;
      assign prv[i] = pv;
    end
  endgenerate
endmodule

// File: rtl/qrt_prescaler.sv
module qrt_prescaler #(
  parameter int SEL_W = 3,
  parameter int BASE  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int CW = BASE + (1 << SEL_W) - 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] mask;

  always_comb begin
    mask = {CW{1'b1}} >> (CW - BASE - int'(sel));
    tick = (cnt & mask) == mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/qrt_aux_cell.sv
module qrt_aux_cell
  import qrt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  aux_mode_t    mode,
  input  logic         fall_sel,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         pin_rise,
  input  logic [W-1:0] core_val,
  input  logic         wrap_rise,
  input  logic         wrap_fall,
  input  logic         grant,
  output logic [W-1:0] value,
  output logic         load_req,
  output logic         cap_evt,
  output logic         irq
);
  logic latch_hit;

  always_comb begin
    latch_hit = fall_sel ? wrap_fall : wrap_rise;
    load_req  = ((mode == AM_PIN_LOAD) && pin_rise) ||
                ((mode == AM_LATCH_LOAD) && latch_hit);
    cap_evt   = (mode == AM_CAPTURE) && pin_rise && !wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
      irq   <= 1'b0;
    end else begin
      if (wr)           value <= wdata;
      else if (cap_evt) value <= core_val;
      irq <= cap_evt | grant;
    end
  end
endmodule

// File: rtl/qrt_timer.sv
module qrt_timer
  import qrt_pkg::*;
#(
  parameter int W     = 16,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       core_mode,
  input  logic [SEL_W-1:0] prescale_sel,
  input  logic             count_down,
  input  logic             ext_dir_en,
  input  logic [1:0]       edge_sel,
  input  logic             gate_level,
  input  logic             cnt_in,
  input  logic             dir_in,
  input  logic             aux_a_in,
  input  logic             aux_b_in,
  input  logic [1:0]       aux_a_mode,
  input  logic             aux_a_fall,
  input  logic [1:0]       aux_b_mode,
  input  logic             aux_b_fall,
  input  logic             core_wr,
  input  logic [W-1:0]     core_wdata,
  input  logic             aux_a_wr,
  input  logic [W-1:0]     aux_a_wdata,
  input  logic             aux_b_wr,
  input  logic [W-1:0]     aux_b_wdata,
  output logic [W-1:0]     core_value,
  output logic             toggle_out,
  output logic             core_irq,
  output logic [W-1:0]     aux_a_value,
  output logic             aux_a_irq,
  output logic [W-1:0]     aux_b_value,
  output logic             aux_b_irq
);
  localparam int           NPIN = 4;
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] TOP  = {W{1'b1}};

  function automatic logic [W-1:0] step_val(input logic [W-1:0] v, input logic up);
    return up ? v + ONE : v - ONE;
  endfunction

  function automatic logic at_end(input logic [W-1:0] v, input logic up);
    return up ? (v == TOP) : (v == '0);
  endfunction

  // lane order: 0 count/phase A, 1 direction/phase B, 2 aux A pin, 3 aux B pin
  logic [NPIN-1:0] pin_lvl, pin_prv, pin_rise, pin_fall;
  logic            tick;
  core_mode_t      cmode;
  logic            up_sw, step_evt, step_up, a_chg, b_chg;
  logic            wrap_evt, wrap_rise, wrap_fall;
  logic            req_a, req_b, grant_a, grant_b, load_evt;
  logic            cap_a_evt, cap_b_evt;

  qrt_insync #(.N(NPIN)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .raw({aux_b_in, aux_a_in, dir_in, cnt_in}),
    .lvl(pin_lvl), .prv(pin_prv)
  );

  assign pin_rise = pin_lvl & ~pin_prv;
  assign pin_fall = ~pin_lvl & pin_prv;

  qrt_prescaler #(.SEL_W(SEL_W), .BASE(3)) u_pre (
    .clk(clk), .rst_n(rst_n), .sel(prescale_sel), .tick(tick)
  );

  always_comb begin
    cmode    = core_mode_t'(core_mode);
    up_sw    = ~(count_down ^ (ext_dir_en & pin_lvl[1]));
    a_chg    = pin_lvl[0] ^ pin_prv[0];
    b_chg    = pin_lvl[1] ^ pin_prv[1];
    step_evt = 1'b0;
    step_up  = up_sw;
    case (cmode)
      CM_TIMER: step_evt = tick;
      CM_GATED: step_evt = tick && (pin_lvl[0] == gate_level);
      CM_COUNT: step_evt = (edge_sel[0] && pin_rise[0]) || (edge_sel[1] && pin_fall[0]);
      CM_QUAD: begin
        step_evt = a_chg ^ b_chg;
        step_up  = quad_up(pin_lvl[0], pin_prv[1]);
      end
      default: step_evt = 1'b0;
    endcase
    wrap_evt  = step_evt && !core_wr && at_end(core_value, step_up);
    wrap_rise = wrap_evt && !toggle_out;
    wrap_fall = wrap_evt && toggle_out;
    grant_a   = req_a && !core_wr;
    grant_b   = req_b && !req_a && !core_wr;
    load_evt  = core_wr || grant_a || grant_b;
  end

  qrt_aux_cell #(.W(W)) u_aux_a (
    .clk(clk), .rst_n(rst_n), .mode(aux_mode_t'(aux_a_mode)), .fall_sel(aux_a_fall),
    .wr(aux_a_wr), .wdata(aux_a_wdata), .pin_rise(pin_rise[2]), .core_val(core_value),
    .wrap_rise(wrap_rise), .wrap_fall(wrap_fall), .grant(grant_a),
    .value(aux_a_value), .load_req(req_a), .cap_evt(cap_a_evt), .irq(aux_a_irq)
  );

  qrt_aux_cell #(.W(W)) u_aux_b (
    .clk(clk), .rst_n(rst_n), .mode(aux_mode_t'(aux_b_mode)), .fall_sel(aux_b_fall),
    .wr(aux_b_wr), .wdata(aux_b_wdata), .pin_rise(pin_rise[3]), .core_val(core_value),
    .wrap_rise(wrap_rise), .wrap_fall(wrap_fall), .grant(grant_b),
    .value(aux_b_value), .load_req(req_b), .cap_evt(cap_b_evt), .irq(aux_b_irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_value <= '0;
      toggle_out <= 1'b0;
      core_irq   <= 1'b0;
    end else begin
      if (core_wr)       core_value <= core_wdata;
      else if (grant_a)  core_value <= aux_a_value;
      else if (grant_b)  core_value <= aux_b_value;
      else if (step_evt) core_value <= step_val(core_value, step_up);
      toggle_out <= toggle_out ^ wrap_evt;
      core_irq   <= wrap_evt;
    end
  end
endmodule

// File: rtl/qrt_timer_chk.sv
module qrt_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] core_value,
  input logic         toggle_out,
  input logic         core_irq,
  input logic         load_evt,
  input logic         aux_a_wr,
  input logic         cap_a_evt,
  input logic [W-1:0] aux_a_value,
  input logic         aux_b_wr,
  input logic         cap_b_evt,
  input logic [W-1:0] aux_b_value
);
  logic [W-1:0] prev_core;
  logic         prev_load;
  logic [W-1:0] delta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_core <= '0;
      prev_load <= 1'b0;
    end else begin
      prev_core <= core_value;
      prev_load <= load_evt;
    end
  end

  assign delta = core_value - prev_core;

  // R7
  toggle_needs_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (toggle_out != $past(toggle_out)) |-> core_irq);

  // R7
  irq_needs_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_irq |-> (toggle_out != $past(toggle_out)));

  // R11
  aux_a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!aux_a_wr && !cap_a_evt) |-> (aux_a_value == $past(aux_a_value)));

  // R11
  aux_b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!aux_b_wr && !cap_b_evt) |-> (aux_b_value == $past(aux_b_value)));

  // R2
  core_unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!prev_load && core_value != prev_core) |-> (delta == {{(W-1){1'b0}}, 1'b1} || delta == {W{1'b1}}));
endmodule

bind qrt_timer qrt_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .core_value(core_value), .toggle_out(toggle_out),
  .core_irq(core_irq), .load_evt(load_evt), .aux_a_wr(aux_a_wr), .cap_a_evt(cap_a_evt),
  .aux_a_value(aux_a_value), .aux_b_wr(aux_b_wr), .cap_b_evt(cap_b_evt),
  .aux_b_value(aux_b_value)
);

// File: tb/qrt_timer_test.sv
`timescale 1ns/1ps
module qrt_timer_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [1:0]  core_mode = 2'b00;
  logic [2:0]  prescale_sel = 3'd0;
  logic        count_down = 0, ext_dir_en = 0, gate_level = 1;
  logic [1:0]  edge_sel = 2'b00;
  logic        cnt_in = 0, dir_in = 0, aux_a_in = 0, aux_b_in = 0;
  logic [1:0]  aux_a_mode = 2'b00, aux_b_mode = 2'b00;
  logic        aux_a_fall = 0, aux_b_fall = 0;
  logic        core_wr = 0, aux_a_wr = 0, aux_b_wr = 0;
  logic [15:0] core_wdata = 0, aux_a_wdata = 0, aux_b_wdata = 0;
  logic [15:0] core_value, aux_a_value, aux_b_value;
  logic        toggle_out, core_irq, aux_a_irq, aux_b_irq;

  qrt_timer uut (
    .clk(clk), .rst_n(rst_n), .core_mode(core_mode), .prescale_sel(prescale_sel),
    .count_down(count_down), .ext_dir_en(ext_dir_en), .edge_sel(edge_sel),
    .gate_level(gate_level), .cnt_in(cnt_in), .dir_in(dir_in), .aux_a_in(aux_a_in),
    .aux_b_in(aux_b_in), .aux_a_mode(aux_a_mode), .aux_a_fall(aux_a_fall),
    .aux_b_mode(aux_b_mode), .aux_b_fall(aux_b_fall), .core_wr(core_wr),
    .core_wdata(core_wdata), .aux_a_wr(aux_a_wr), .aux_a_wdata(aux_a_wdata),
    .aux_b_wr(aux_b_wr), .aux_b_wdata(aux_b_wdata), .core_value(core_value),
    .toggle_out(toggle_out), .core_irq(core_irq), .aux_a_value(aux_a_value),
    .aux_a_irq(aux_a_irq), .aux_b_value(aux_b_value), .aux_b_irq(aux_b_irq)
  );

  int checks = 0;
  int bad = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  int mc, ma, mb, pc;
  bit mlat, mirq, mairq, mbirq;
  logic [3:0] hq[$];

  always @(posedge clk) begin : model
    logic [3:0] lv, pv, ri, fa;
    int dv, nc;
    bit tk, st, up, upsw, wrp, rising, falling, req_a, req_b, cap_a, cap_b, ga, gb;
    if (!rst_n) begin
      mc = 0; ma = 0; mb = 0; pc = 0;
      mlat = 0; mirq = 0; mairq = 0; mbirq = 0;
      hq = '{4'h0, 4'h0, 4'h0};
    end else begin
      lv = hq[1]; pv = hq[2];
      ri = lv & ~pv; fa = ~lv & pv;
      dv = 1 << (int'(prescale_sel) + 3);
      tk = (pc % dv) == dv - 1;
      pc = pc + 1;
      upsw = !(count_down ^ (ext_dir_en & lv[1]));
      up = upsw;
      st = 0;
      case (core_mode)
        2'b00: st = tk;
        2'b01: st = tk && (lv[0] == gate_level);
        2'b10: st = (edge_sel[0] && ri[0]) || (edge_sel[1] && fa[0]);
        default: begin
          st = (lv[0] != pv[0]) ^ (lv[1] != pv[1]);
          up = lv[0] ^ pv[1];
        end
      endcase
      wrp = st && !core_wr && (up ? (mc == 16'hFFFF) : (mc == 0));
      rising = wrp && !mlat;
      falling = wrp && mlat;
      req_a = (aux_a_mode == 2'b10 && ri[2]) || (aux_a_mode == 2'b11 && (aux_a_fall ? falling : rising));
      req_b = (aux_b_mode == 2'b10 && ri[3]) || (aux_b_mode == 2'b11 && (aux_b_fall ? falling : rising));
      cap_a = aux_a_mode == 2'b01 && ri[2] && !aux_a_wr;
      cap_b = aux_b_mode == 2'b01 && ri[3] && !aux_b_wr;
      ga = req_a && !core_wr;
      gb = req_b && !req_a && !core_wr;
      if (core_wr) nc = int'(core_wdata);
      else if (ga) nc = ma;
      else if (gb) nc = mb;
      else if (st) nc = up ? ((mc + 1) & 16'hFFFF) : ((mc + 65535) & 16'hFFFF);
      else nc = mc;
      if (aux_a_wr) ma = int'(aux_a_wdata); else if (cap_a) ma = mc;
      if (aux_b_wr) mb = int'(aux_b_wdata); else if (cap_b) mb = mc;
      mc = nc;
      mlat = mlat ^ wrp;
      mirq = wrp;
      mairq = cap_a || ga;
      mbirq = cap_b || gb;
      hq.push_front({aux_b_in, aux_a_in, dir_in, cnt_in});
      void'(hq.pop_back());
    end
  end

  // per-clock comparison and PWM interval monitor
  int since = 0, hi_len = 0, lo_len = 0;
  bit lastt = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2", "core_value vs model", int'(core_value), mc);
      chk("R7", "toggle_out vs model", int'(toggle_out), int'(mlat));
      chk("R7", "core_irq vs model", int'(core_irq), int'(mirq));
      chk("R8", "aux_a_value vs model", int'(aux_a_value), ma);
      chk("R8", "aux_b_value vs model", int'(aux_b_value), mb);
      chk("R9", "aux_a_irq vs model", int'(aux_a_irq), int'(mairq));
      chk("R9", "aux_b_irq vs model", int'(aux_b_irq), int'(mbirq));
      since++;
      if (toggle_out != lastt) begin
        if (lastt) hi_len = since; else lo_len = since;
        since = 0;
        lastt = toggle_out;
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_core(input logic [15:0] v);
    core_wdata = v; core_wr = 1; cyc(1); core_wr = 0;
  endtask

  task automatic wr_a(input logic [15:0] v);
    aux_a_wdata = v; aux_a_wr = 1; cyc(1); aux_a_wr = 0;
  endtask

  task automatic wr_b(input logic [15:0] v);
    aux_b_wdata = v; aux_b_wr = 1; cyc(1); aux_b_wr = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin : main
    bit t0;
    cyc(3);
    // R1 reset state
    chk("R1", "core after reset", int'(core_value), 0);
    chk("R1", "aux a after reset", int'(aux_a_value), 0);
    chk("R1", "toggle/irqs after reset", int'({toggle_out, core_irq, aux_a_irq, aux_b_irq}), 0);
    rst_n = 1;
    cyc(2);

    // R2 timer mode, divide by 8 then by 32
    wr_core(16'h0000); cyc(64);
    chk("R2", "timer /8 over 64 clocks", int'(core_value), 8);
    prescale_sel = 3'd2; wr_core(16'h0000); cyc(128);
    chk("R2", "timer /32 over 128 clocks", int'(core_value), 4);
    prescale_sel = 3'd0;

    // R3 gated mode
    core_mode = 2'b01; gate_level = 1; cnt_in = 1; cyc(3);
    wr_core(16'h0000); cyc(64);
    chk("R3", "gate open count", int'(core_value), 8);
    cnt_in = 0; cyc(3); wr_core(16'h0000); cyc(64);
    chk("R3", "gate closed count", int'(core_value), 0);

    // R4 counter mode, both edges then rising only
    core_mode = 2'b10; edge_sel = 2'b11; cyc(3);
    wr_core(16'h0000);
    for (int i = 0; i < 6; i++) begin cnt_in = ~cnt_in; cyc(4); end
    cyc(4);
    chk("R4", "both-edge count", int'(core_value), 6);
    edge_sel = 2'b01; wr_core(16'h0000);
    for (int i = 0; i < 6; i++) begin cnt_in = ~cnt_in; cyc(4); end
    cyc(4);
    chk("R4", "rising-edge count", int'(core_value), 3);

    // R5 external direction pin, with R7 underflow wrap
    core_mode = 2'b00; ext_dir_en = 1; dir_in = 1; cyc(3);
    t0 = toggle_out;
    wr_core(16'h0003); cyc(64);
    chk("R5", "external down count", int'(core_value), 16'hFFFB);
    chk("R7", "toggle flipped on underflow", int'(toggle_out), int'(!t0));
    dir_in = 0; ext_dir_en = 0;
    count_down = 1; wr_core(16'h0010); cyc(64);
    chk("R5", "software down count", int'(core_value), 16'h0008);
    count_down = 0;

    // R6 two-phase sensor
    core_mode = 2'b11; cnt_in = 0; dir_in = 0; cyc(4);
    wr_core(16'd100);
    cnt_in = 1; cyc(4); dir_in = 1; cyc(4); cnt_in = 0; cyc(4); dir_in = 0; cyc(4);
    chk("R6", "four forward steps", int'(core_value), 104);
    dir_in = 1; cyc(4); cnt_in = 1; cyc(4);
    chk("R6", "two backward steps", int'(core_value), 102);
    cnt_in = 0; dir_in = 0; cyc(4);
    chk("R6", "both phases together ignored", int'(core_value), 102);

    // R8 capture, R11 hold mode
    core_mode = 2'b10; edge_sel = 2'b00; cyc(4);
    wr_core(16'h1234);
    aux_a_mode = 2'b01; aux_a_in = 1; cyc(4); aux_a_in = 0; cyc(4);
    chk("R8", "capture into A", int'(aux_a_value), 16'h1234);
    aux_a_mode = 2'b00; wr_core(16'h5555);
    aux_a_in = 1; cyc(4); aux_a_in = 0; cyc(4);
    chk("R11", "hold mode ignores pin", int'(aux_a_value), 16'h1234);

    // R9 pin reload from B
    wr_b(16'hBEEF); aux_b_mode = 2'b10;
    aux_b_in = 1; cyc(4); aux_b_in = 0; cyc(4);
    chk("R9", "pin reload from B", int'(core_value), 16'hBEEF);

    // R10 / R12 latch reloads forming PWM
    core_mode = 2'b00; prescale_sel = 3'd0;
    aux_a_mode = 2'b11; aux_a_fall = 0; aux_b_mode = 2'b11; aux_b_fall = 1;
    wr_a(16'hFFF0); wr_b(16'hFFE0); wr_core(16'hFFF0);
    cyc(1300);
    chk("R12", "PWM high time", hi_len, 128);
    chk("R10", "PWM low time", lo_len, 256);
    chk("R11", "A unchanged by reloads", int'(aux_a_value), 16'hFFF0);
    chk("R11", "B unchanged by reloads", int'(aux_b_value), 16'hFFE0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule